// File: doc/BRIEF.md
# Sensor Channel Sequencer Controller

This block runs an analog sensor front end through a set of voltage channels and streams out each result. Software writes one command word through a 32-bit, word-addressed register port. The command chooses one of three fixed channel ranges or a single channel. It also chooses between single-shot and continuous operation, and it holds a run bit that starts the work. A calibration-output select bit and two unipolar select bits go straight through to the converter.

The block drives the converter with a level request and a channel number, and it waits for a one-cycle done pulse that carries a 6-bit result. Each result leaves on a streaming source with valid/ready flow control. Every beat carries the channel number and the sample. Start-of-packet and end-of-packet frame one pass over the selected range. The block issues only one conversion at a time. It does not request the next conversion until the sink has taken the previous result.

In single-shot mode the run bit clears itself when the pass ends. In continuous mode the pass repeats until software writes the run bit to 0. The block then completes the conversion it has started, delivers that result and clears the run bit.

Top module: `sensor_seq_ctrl`

## Requirements
- R1: The command word sits at word address 0. Its fields are: bit 0 run, bit 1 continuous, bits 3:2 range select, bits 6:4 single-channel number, bit 8 calibrated-output select, bits 10:9 unipolar select for channels 1 and 0. A read of address 0 returns these fields with the live run bit and all other bits 0. A read of any other address returns 0. After reset the word is 0.
- R2: Range select 00 converts channels 0,1. Range select 01 converts channels 0 through 7. Range select 10 converts channels 2 through 7. Channels are always converted in ascending order.
- R3: Range select 11 converts only the channel given in bits 6:4.
- R4: In single-shot mode (bit 1 = 0), setting run performs exactly one pass. The run bit reads 0 after the last result of that pass is accepted, and no further conversion request follows.
- R5: In continuous mode with a range selected, the pass restarts at the first channel of the range right after the last channel is delivered.
- R6: In continuous mode with range select 11, the chosen channel is converted again and again until run is written to 0.
- R7: Writing 0 to run while it is set stops the block without cutting the current conversion short. A result that is pending or being converted at the time of the write is delivered, no new request starts, and then the run bit clears.
- R8: Each beat carries the 6-bit converter result and its channel number. Start-of-packet is set on the first channel of a pass and end-of-packet on the last. A single-channel pass sets both on the same beat.
- R9: The calibrated-output bit and the unipolar bits of the command word drive the converter outputs directly.
- R10: While run is set, a write to the command word changes nothing except that run = 0 requests a stop. The range, channel, continuous and pass-through fields keep their values, and run = 1 has no effect.
- R11: While valid is high and ready is low, the beat's valid, channel, data and framing stay unchanged. No conversion request is raised while a result is pending.
- R12: The conversion request stays high, with its channel unchanged, until done is seen. A done pulse that arrives while no request is raised is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | CSR_AW | Word address of the register access |
| csr_read | input | 1 | Read strobe; data returned in the same cycle |
| csr_write | input | 1 | Write strobe |
| csr_wdata | input | CSR_DW | Write data |
| csr_rdata | output | CSR_DW | Read data |
| conv_req | output | 1 | Conversion request, held until done |
| conv_ch | output | 3 | Channel to convert |
| conv_cal | output | 1 | Calibrated-output select passed to the converter |
| conv_unipolar | output | 2 | Unipolar selects for channels 1 and 0 |
| conv_done | input | 1 | One-cycle pulse: conversion finished |
| conv_data | input | SAMPLE_W | Converter result, valid with conv_done |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Stream sink ready |
| st_channel | output | 3 | Channel of the current beat |
| st_data | output | SAMPLE_W | Sample of the current beat |
| st_sop | output | 1 | First beat of a pass |
| st_eop | output | 1 | Last beat of a pass |

## Verification
The assertions check every cycle that the request and its channel hold until done, that the beat holds under back-pressure, that no request overlaps a pending result, and that the command fields stay frozen while running. Other behaviours depend on a whole scenario and only the bench can show them: the exact channel order of each range, wrap-around in continuous mode, and framing across passes. The same holds for a stop that drains exactly the conversion in flight and for stray done pulses being ignored. The bench compares each beat with a model of the range bounds and the converter's last result, and it mixes random ranges, channels and sink readiness with directed stop and ignored-write cases.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

   localparam int CH_W      = 3;
   localparam int BIT_RUN   = 0;
   localparam int BIT_CONT  = 1;
   localparam int SEL_LSB   = 2;
   localparam int CHSEL_LSB = 4;
   localparam int BIT_CAL   = 8;
   localparam int UNI_LSB   = 9;
   localparam int CMD_BITS  = UNI_LSB + 2;

   typedef enum logic [1:0] {
      SEQ_LOW2  = 2'b00,
      SEQ_ALL8  = 2'b01,
      SEQ_UPPER = 2'b10,
      SEQ_ONE   = 2'b11
   } seq_sel_e;

   typedef struct packed {
      logic [1:0]      unipolar;
      logic            cal;
      logic [CH_W-1:0] chsel;
      seq_sel_e        sel;
      logic            cont;
   } cmd_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_REQ  = 2'b01,
      ST_HOLD = 2'b10
   } seq_state_e;

   function automatic logic [CH_W-1:0] range_first(seq_sel_e s, logic [CH_W-1:0] one);
      case (s)
         SEQ_LOW2, SEQ_ALL8: return CH_W'(0);
         SEQ_UPPER:          return CH_W'(2);
         default:            return one;
      endcase
   endfunction

   function automatic logic [CH_W-1:0] range_last(seq_sel_e s, logic [CH_W-1:0] one);
      case (s)
         SEQ_LOW2:            return CH_W'(1);
         SEQ_ALL8, SEQ_UPPER: return CH_W'(7);
         default:             return one;
      endcase
   endfunction

endpackage

// File: rtl/sseq_cmd_reg.sv
module sseq_cmd_reg
   import sseq_pkg::*;
#(
   parameter int CSR_AW = 1,
   parameter int CSR_DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic              csr_read,
   input  logic              csr_write,
   input  logic [CSR_DW-1:0] csr_wdata,
   output logic [CSR_DW-1:0] csr_rdata,
   input  logic              pass_done,
   output cmd_cfg_t          cfg,
   output logic              run,
   output logic              stop
);

   logic     run_q, stop_q, wr_hit, stop_now;
   cmd_cfg_t cfg_q;
   logic [CSR_DW-1:0] word;
   logic     unused_wbits;

   assign wr_hit   = csr_write && (csr_addr == '0);
   assign stop_now = run_q && wr_hit && !csr_wdata[BIT_RUN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         run_q  <= 1'b0;
         stop_q <= 1'b0;
      end else if (pass_done) begin
         run_q  <= 1'b0;
         stop_q <= 1'b0;
      end else if (wr_hit) begin
         if (!run_q) begin
            cfg_q.cont     <= csr_wdata[BIT_CONT];
            cfg_q.sel      <= seq_sel_e'(csr_wdata[SEL_LSB +: 2]);
            cfg_q.chsel    <= csr_wdata[CHSEL_LSB +: CH_W];
            cfg_q.cal      <= csr_wdata[BIT_CAL];
            cfg_q.unipolar <= csr_wdata[UNI_LSB +: 2];
            run_q          <= csr_wdata[BIT_RUN];
         end else if (!csr_wdata[BIT_RUN]) begin
            stop_q <= 1'b1;
         end
      end
   end

   always_comb begin
      word                       = '0;
      word[BIT_RUN]              = run_q;
      word[BIT_CONT]             = cfg_q.cont;
      word[SEL_LSB +: 2]         = cfg_q.sel;
      word[CHSEL_LSB +: CH_W]    = cfg_q.chsel;
      word[BIT_CAL]              = cfg_q.cal;
      word[UNI_LSB +: 2]         = cfg_q.unipolar;
   end

   assign csr_rdata = (csr_read && csr_addr == '0) ? word : '0;
   assign cfg       = cfg_q;
   assign run       = run_q;
   assign stop      = stop_q || stop_now;

   generate
      if (CSR_DW > CMD_BITS) begin : g_spare
         assign unused_wbits = ^{csr_wdata[CSR_DW-1:CMD_BITS], csr_wdata[7]};
      end else begin : g_nospare
         assign unused_wbits = csr_wdata[7];
      end
   endgenerate

   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run_q) |-> $stable(cfg_q));

endmodule

// File: rtl/sseq_stepper.sv
module sseq_stepper
   import sseq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            stop,
   input  cmd_cfg_t        cfg,
   output logic            conv_req,
   output logic [CH_W-1:0] conv_ch,
   input  logic            conv_done,
   output logic            load,
   output logic            load_sop,
   output logic            load_eop,
   input  logic            accept,
   output logic            pass_done
);

   seq_state_e      state_q;
   logic [CH_W-1:0] ch_q, first_ch, last_ch;
   logic            at_last, finish;

   assign first_ch  = range_first(cfg.sel, cfg.chsel);
   assign last_ch   = range_last(cfg.sel, cfg.chsel);
   assign at_last   = (ch_q == last_ch);

   assign conv_req  = (state_q == ST_REQ);
   assign conv_ch   = ch_q;
   assign load      = conv_req && conv_done;
   assign load_sop  = (ch_q == first_ch);
   assign load_eop  = at_last;

   assign finish    = accept && (stop || (!cfg.cont && at_last));
   assign pass_done = ((state_q == ST_IDLE) && run && stop) ||
                      ((state_q == ST_HOLD) && finish);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ch_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (run && !stop) begin
                  state_q <= ST_REQ;
                  ch_q    <= first_ch;
               end
            end
            ST_REQ: begin
               if (conv_done) state_q <= ST_HOLD;
            end
            ST_HOLD: begin
               if (finish) begin
                  state_q <= ST_IDLE;
               end else if (accept) begin
                  state_q <= ST_REQ;
                  ch_q    <= at_last ? first_ch : ch_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req && !conv_done |=> conv_req && $stable(conv_ch));

   assert_quiet_after_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !conv_req);

endmodule

// File: rtl/sseq_stream_reg.sv
module sseq_stream_reg #(
   parameter int SAMPLE_W = 6,
   parameter int CHAN_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SAMPLE_W-1:0] in_data,
   input  logic [CHAN_W-1:0]   in_ch,
   input  logic                in_sop,
   input  logic                in_eop,
   input  logic                ready,
   output logic                valid,
   output logic [SAMPLE_W-1:0] data,
   output logic [CHAN_W-1:0]   ch,
   output logic                sop,
   output logic                eop,
   output logic                accept
);

   logic                valid_q, sop_q, eop_q;
   logic [SAMPLE_W-1:0] data_q;
   logic [CHAN_W-1:0]   ch_q;

   assign accept = valid_q && ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         ch_q    <= '0;
         sop_q   <= 1'b0;
         eop_q   <= 1'b0;
      end else if (load) begin
         valid_q <= 1'b1;
         data_q  <= in_data;
         ch_q    <= in_ch;
         sop_q   <= in_sop;
         eop_q   <= in_eop;
      end else if (accept) begin
         valid_q <= 1'b0;
      end
   end

   assign valid = valid_q;
   assign data  = data_q;
   assign ch    = ch_q;
   assign sop   = sop_q;
   assign eop   = eop_q;

   assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && !ready |=> valid_q && $stable(data_q) && $stable(ch_q)
                            && $stable(sop_q) && $stable(eop_q));

   assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !valid_q);

endmodule

// File: rtl/sensor_seq_ctrl.sv
module sensor_seq_ctrl
   import sseq_pkg::*;
#(
   parameter int CSR_AW   = 1,
   parameter int CSR_DW   = 32,
   parameter int SAMPLE_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CSR_AW-1:0]   csr_addr,
   input  logic                csr_read,
   input  logic                csr_write,
   input  logic [CSR_DW-1:0]   csr_wdata,
   output logic [CSR_DW-1:0]   csr_rdata,
   output logic                conv_req,
   output logic [2:0]          conv_ch,
   output logic                conv_cal,
   output logic [1:0]          conv_unipolar,
   input  logic                conv_done,
   input  logic [SAMPLE_W-1:0] conv_data,
   output logic                st_valid,
   input  logic                st_ready,
   output logic [2:0]          st_channel,
   output logic [SAMPLE_W-1:0] st_data,
   output logic                st_sop,
   output logic                st_eop
);

   generate
      if (CSR_AW < 1)         begin : g_bad_aw $error("CSR_AW must be at least 1"); end
      if (CSR_DW < CMD_BITS)  begin : g_bad_dw $error("CSR_DW too narrow for the command word"); end
      if (SAMPLE_W < 1)       begin : g_bad_sw $error("SAMPLE_W must be at least 1"); end
   endgenerate

   cmd_cfg_t        cfg;
   logic            run, stop, pass_done, load, load_sop, load_eop, accept;
   logic [CH_W-1:0] req_ch;

   sseq_cmd_reg #(.CSR_AW(CSR_AW), .CSR_DW(CSR_DW)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_addr  (csr_addr),
      .csr_read  (csr_read),
      .csr_write (csr_write),
      .csr_wdata (csr_wdata),
      .csr_rdata (csr_rdata),
      .pass_done (pass_done),
      .cfg       (cfg),
      .run       (run),
      .stop      (stop)
   );

   sseq_stepper u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .stop      (stop),
      .cfg       (cfg),
      .conv_req  (conv_req),
      .conv_ch   (req_ch),
      .conv_done (conv_done),
      .load      (load),
      .load_sop  (load_sop),
      .load_eop  (load_eop),
      .accept    (accept),
      .pass_done (pass_done)
   );

   sseq_stream_reg #(.SAMPLE_W(SAMPLE_W), .CHAN_W(CH_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .in_data (conv_data),
      .in_ch   (req_ch),
      .in_sop  (load_sop),
      .in_eop  (load_eop),
      .ready   (st_ready),
      .valid   (st_valid),
      .data    (st_data),
      .ch      (st_channel),
      .sop     (st_sop),
      .eop     (st_eop),
      .accept  (accept)
   );

   assign conv_ch       = req_ch;
   assign conv_cal      = cfg.cal;
   assign conv_unipolar = cfg.unipolar;

   assert_req_not_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_req && st_valid));

endmodule

// File: tb/tb_sensor_seq_ctrl.sv
module tb_sensor_seq_ctrl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [0:0]  csr_addr = '0;
   logic        csr_read = 1'b0;
   logic        csr_write = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        conv_req;
   logic [2:0]  conv_ch;
   logic        conv_cal;
   logic [1:0]  conv_unipolar;
   logic        conv_done = 1'b0;
   logic [5:0]  conv_data = '0;
   logic        st_valid;
   logic        st_ready = 1'b1;
   logic [2:0]  st_channel;
   logic [5:0]  st_data;
   logic        st_sop;
   logic        st_eop;

   int checks = 0;
   int fails = 0;
   int beat_cnt = 0;
   int sop_cnt = 0;
   int mon_first = 0;
   int mon_last = 0;
   int mon_idx = 0;
   int ready_pct = 100;
   bit spurious_en = 1'b0;
   bit finished = 1'b0;
   logic [5:0] model_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sensor_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .csr_addr(csr_addr), .csr_read(csr_read), .csr_write(csr_write),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .conv_req(conv_req), .conv_ch(conv_ch), .conv_cal(conv_cal),
      .conv_unipolar(conv_unipolar), .conv_done(conv_done), .conv_data(conv_data),
      .st_valid(st_valid), .st_ready(st_ready), .st_channel(st_channel),
      .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rng_first(int mode, int chsel);
      case (mode)
         0, 1:    return 0;
         2:       return 2;
         default: return chsel;
      endcase
   endfunction

   function automatic int rng_last(int mode, int chsel);
      case (mode)
         0:       return 1;
         1, 2:    return 7;
         default: return chsel;
      endcase
   endfunction

   function automatic logic [31:0] mkcmd(int run, int cont, int mode, int chsel, int cal, int uni);
      return 32'(run & 1) | (32'(cont & 1) << 1) | (32'(mode & 3) << 2) |
             (32'(chsel & 7) << 4) | (32'(cal & 1) << 8) | (32'(uni & 3) << 9);
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic csr_wr(input logic [0:0] a, input logic [31:0] d);
      csr_addr = a; csr_wdata = d; csr_write = 1'b1;
      tick();
      csr_write = 1'b0;
   endtask

   task automatic csr_rd(input logic [0:0] a, output logic [31:0] d);
      csr_addr = a; csr_read = 1'b1;
      @(negedge clk);
      d = csr_rdata;
      tick();
      csr_read = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] d;
      int n;
      n = 0;
      d = 32'h1;
      while (d[0] && n < 3000) begin
         csr_rd(1'b0, d);
         n++;
      end
      chk(!d[0], tag, int'(d[0]), 0);
   endtask

   task automatic quiet(input string tag);
      int q;
      q = 0;
      repeat (12) begin
         tick();
         if (conv_req || st_valid) q++;
      end
      chk(q == 0, tag, q, 0);
   endtask

   task automatic arm_monitor(int mode, int chsel);
      mon_first = rng_first(mode, chsel);
      mon_last  = rng_last(mode, chsel);
      mon_idx   = 0;
   endtask

   task automatic one_shot(int mode, int chsel, int cal, int uni);
      int b0;
      arm_monitor(mode, chsel);
      b0 = beat_cnt;
      csr_wr(1'b0, mkcmd(1, 0, mode, chsel, cal, uni));
      wait_idle("R4 run bit clears after single pass");
      chk(beat_cnt - b0 == mon_last - mon_first + 1,
          (mode == 3) ? "R3 R12 single-channel beat count" : "R2 R12 range beat count",
          beat_cnt - b0, mon_last - mon_first + 1);
      quiet("R4 no request after single pass");
   endtask

   task automatic wait_beats(int n, input string tag);
      int b0, t;
      b0 = beat_cnt;
      t = 0;
      while (beat_cnt - b0 < n && t < 5000) begin
         tick();
         t++;
      end
      chk(beat_cnt - b0 >= n, tag, beat_cnt - b0, n);
   endtask

   task automatic stop_run(input string tag);
      int b1, exp_after;
      exp_after = (conv_req || st_valid) ? 1 : 0;
      b1 = beat_cnt;
      csr_wr(1'b0, 32'h0);
      wait_idle("R7 run bit clears after stop");
      chk(beat_cnt - b1 == exp_after, tag, beat_cnt - b1, exp_after);
      quiet("R7 no request after stop");
   endtask

   // converter model
   initial begin : conv_model
      int dly;
      dly = 0;
      forever begin
         tick();
         conv_done = 1'b0;
         if (conv_req) begin
            if (dly == 0) begin
               conv_done  = 1'b1;
               conv_data  = 6'($urandom);
               model_data = conv_data;
               dly        = $urandom % 4;
            end else begin
               dly--;
            end
         end else if (spurious_en && ($urandom % 6 == 0)) begin
            conv_done = 1'b1;
            conv_data = 6'($urandom);
         end
      end
   end

   // sink readiness
   initial begin : sink_drv
      forever begin
         tick();
         st_ready = (($urandom % 100) < ready_pct);
      end
   end

   // stream monitor
   logic       prev_hold = 1'b0;
   logic [5:0] prev_data;
   logic [2:0] prev_ch;
   logic       prev_sop, prev_eop;

   always @(negedge clk) begin
      if (rst_n) begin
         if (conv_req && st_valid) chk(1'b0, "R11 request while result pending", 1, 0);
         if (prev_hold)
            chk(st_valid && st_data == prev_data && st_channel == prev_ch &&
                st_sop == prev_sop && st_eop == prev_eop,
                "R11 beat held under back-pressure", int'(st_data), int'(prev_data));
         prev_hold = st_valid && !st_ready;
         prev_data = st_data; prev_ch = st_channel;
         prev_sop  = st_sop;  prev_eop = st_eop;
         if (st_valid && st_ready) begin
            int exp_ch;
            exp_ch = mon_first + mon_idx;
            chk(int'(st_channel) == exp_ch, "R2 R3 R5 channel order", int'(st_channel), exp_ch);
            chk(st_data == model_data, "R8 sample data", int'(st_data), int'(model_data));
            chk(st_sop == (mon_idx == 0), "R8 start-of-packet", int'(st_sop), int'(mon_idx == 0));
            chk(st_eop == (exp_ch == mon_last), "R8 end-of-packet", int'(st_eop), int'(exp_ch == mon_last));
            beat_cnt++;
            if (st_sop) sop_cnt++;
            mon_idx = (exp_ch == mon_last) ? 0 : mon_idx + 1;
         end
      end
   end

   // watchdog
   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      int s0, b0;
      void'($urandom(32'h5EED_1234));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      csr_rd(1'b0, d);
      chk(d == 32'h0, "R1 reset word", int'(d), 0);
      chk(!conv_req && !st_valid, "R1 reset outputs idle", int'(conv_req), 0);

      // R1 / R9: configure while idle, run = 0
      csr_wr(1'b0, mkcmd(0, 1, 2, 5, 1, 2) | 32'hFFFF_F880);
      csr_rd(1'b0, d);
      chk(d == mkcmd(0, 1, 2, 5, 1, 2), "R1 readback fields", int'(d), int'(mkcmd(0, 1, 2, 5, 1, 2)));
      csr_rd(1'b1, d);
      chk(d == 32'h0, "R1 other address reads zero", int'(d), 0);
      chk(conv_cal == 1'b1 && conv_unipolar == 2'b10, "R9 pass-through bits",
          int'({conv_cal, conv_unipolar}), 6);
      quiet("R1 no activity with run clear");

      // directed single-shot passes over all ranges
      spurious_en = 1'b1;
      one_shot(0, 0, 0, 1);
      chk(conv_unipolar == 2'b01 && conv_cal == 1'b0, "R9 pass-through after pass",
          int'({conv_cal, conv_unipolar}), 1);
      one_shot(1, 3, 1, 0);
      one_shot(2, 0, 0, 3);
      one_shot(3, 7, 0, 0);
      one_shot(3, 0, 1, 1);

      // continuous range 2..7 with back-pressure, ignored writes, stop
      ready_pct = 40;
      arm_monitor(2, 0);
      s0 = sop_cnt;
      csr_wr(1'b0, mkcmd(1, 1, 2, 0, 0, 0));
      wait_beats(14, "R5 continuous range keeps running");
      chk(sop_cnt - s0 >= 2, "R5 range restarted", sop_cnt - s0, 2);
      csr_wr(1'b0, mkcmd(1, 0, 0, 4, 1, 3));
      csr_rd(1'b0, d);
      chk(d[10:1] == mkcmd(1, 1, 2, 0, 0, 0) >> 1 && d[0], "R10 fields frozen while running",
          int'(d), int'(mkcmd(1, 1, 2, 0, 0, 0)));
      chk(conv_cal == 1'b0 && conv_unipolar == 2'b00, "R10 pass-through unchanged",
          int'({conv_cal, conv_unipolar}), 0);
      wait_beats(6, "R10 still continuous after ignored write");
      stop_run("R7 stop drains in-flight conversion only");

      // continuous single channel
      ready_pct = 70;
      arm_monitor(3, 6);
      s0 = sop_cnt;
      b0 = beat_cnt;
      csr_wr(1'b0, mkcmd(1, 1, 3, 6, 0, 0));
      wait_beats(10, "R6 single channel repeats");
      chk(sop_cnt - s0 == beat_cnt - b0, "R8 single beat carries both marks",
          sop_cnt - s0, beat_cnt - b0);
      stop_run("R6 R7 stop of single-channel repeat");

      // stop issued right after start
      arm_monitor(1, 0);
      csr_wr(1'b0, mkcmd(1, 1, 1, 0, 0, 0));
      stop_run("R7 stop right after start");

      // randomized single-shot passes
      for (int i = 0; i < 30; i++) begin
         ready_pct = 30 + ($urandom % 71);
         one_shot($urandom % 4, $urandom % 8, $urandom % 2, $urandom % 4);
      end

      // randomized continuous runs with stop
      for (int i = 0; i < 6; i++) begin
         int m, c;
         m = $urandom % 4;
         c = $urandom % 8;
         ready_pct = 30 + ($urandom % 71);
         arm_monitor(m, c);
         csr_wr(1'b0, mkcmd(1, 1, m, c, 0, 0));
         wait_beats(3 + ($urandom % 10), "R5 R6 random continuous run");
         stop_run("R7 random stop");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule